// File: doc/BRIEF.md
# Exception return control unit

This unit carries out the return-from-exception operation of a small pipelined 32-bit processor. It watches the decode stage for the return instruction, reads the base register index out of the word, takes the base value the register file hands back in the same cycle, and adds the sign-extended 16-bit immediate to it. The sum becomes the fetch redirect target. The redirect is issued only after the one instruction that follows the return, its delay slot, has been accepted.

In the cycle the redirect is presented, the unit also drives a write of the machine status bits. Exceptions are re-enabled, the in-progress mark is cleared, and the saved user-mode and virtual-mode bits become the live ones. While memory management is configured (a parameter), a return attempted in user mode does not redirect at all. Instead it produces a one-cycle privileged-instruction exception together with a cause code for the exception status register.

From the return's decode through the redirect cycle, interrupt and hardware-break requests are withheld. A delay-slot instruction of a forbidden type is reported with a flag.

Top module: `rted_unit`

## Requirements
- R1: A word is taken as the return instruction only when `instr_valid` is high, the unit is idle, bits [31:26] equal 101101 and bits [25:21] equal 10100. Any other word leaves the unit idle. `base_idx` always shows bits [20:16] of `instr`.
- R2: `branch_target` equals `base_val` sampled at decode plus bits [15:0] of the instruction sign-extended to 32 bits, with wrap-around. It is valid while `branch_valid` is high.
- R3: After decode the unit waits, busy, for the delay-slot instruction (`instr_valid` high). `branch_valid` is high for exactly the one cycle after the slot is accepted, so the minimum sequence is decode, slot, redirect. Stalls in the slot wait add cycles without a redirect.
- R4: With `PRIV_CHECK` nonzero and `cur_um` high at decode, there is no redirect and no status write. `priv_exc` and `esr_we` pulse for one cycle, the cycle after decode, with `esr_cause` = 00111.
- R5: With `PRIV_CHECK` zero, the return proceeds whatever `cur_um` holds.
- R6: In the redirect cycle `st_we`=1, `st_ee`=1 and `st_eip`=0.
- R7: In the redirect cycle `st_um` equals `cur_ums` and `st_vm` equals `cur_vms`, both sampled at decode.
- R8: `irq_take` follows `irq_req` and `brk_take` follows `brk_req`, except from the decode cycle through the redirect cycle, when both are 0.
- R9: `ds_illegal` is high in the redirect cycle when the slot opcode (bits [31:26]) is 101100 (immediate prefix), 100110, 100111, 101110 or 101111 (branch and break forms), or 101101 (this return).
- R10: While `rst_n` is low and right after, the unit is idle and every output is 0. A reset during the sequence abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | A decoded-stage instruction is present |
| instr | input | 32 | Instruction word, bit 31 is the leftmost field bit |
| base_val | input | 32 | Register file value for `base_idx` |
| cur_um | input | 1 | Live user-mode bit |
| cur_ums | input | 1 | Saved user-mode bit |
| cur_vms | input | 1 | Saved virtual-mode bit |
| irq_req | input | 1 | Pending interrupt request |
| brk_req | input | 1 | Pending external hardware break |
| base_idx | output | 5 | Base register index for the register file read |
| busy | output | 1 | Return sequence in progress |
| branch_valid | output | 1 | Fetch redirect present |
| branch_target | output | 32 | Redirect address |
| st_we | output | 1 | Status bit write strobe |
| st_ee | output | 1 | New exception-enable bit |
| st_eip | output | 1 | New exception-in-progress bit |
| st_um | output | 1 | New user-mode bit |
| st_vm | output | 1 | New virtual-mode bit |
| priv_exc | output | 1 | Privileged-instruction exception pulse |
| esr_we | output | 1 | Exception status register write strobe |
| esr_cause | output | 5 | Cause code for the exception status register |
| irq_take | output | 1 | Interrupt may be taken |
| brk_take | output | 1 | Hardware break may be taken |
| ds_illegal | output | 1 | Forbidden instruction in the delay slot |

## Verification
The vector table pairs base values and immediates chosen to separate correct sign extension from zero extension: small positive, negative, the most negative immediate, and a sum that wraps past the top of the address space. Each is paired with distinct saved-mode bit combinations, so a swapped or unsampled saved bit shows up. Delay-slot opcodes cover ordinary instructions and every forbidden class, which tells a complete forbidden-opcode check from a partial one. User-mode vectors run against two instances, one with the privilege check and one without, and this separates the exception path from the return path. Directed cases add a near-miss encoding, a stalled slot, and a reset in mid-sequence.

// File: rtl/rtedu_pkg.sv
// Shared definitions for the exception return unit.
// Assumes 32-bit instruction words with the opcode in the top six bits.
package rtedu_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int SUB_W   = 5;
    localparam int IDX_W   = 5;

    localparam logic [OPC_W-1:0] OPC_RET  = 6'b101101;
    localparam logic [OPC_W-1:0] OPC_IMM  = 6'b101100;
    localparam logic [OPC_W-1:0] OPC_BR   = 6'b100110;
    localparam logic [OPC_W-1:0] OPC_BRC  = 6'b100111;
    localparam logic [OPC_W-1:0] OPC_BRI  = 6'b101110;
    localparam logic [OPC_W-1:0] OPC_BRCI = 6'b101111;
    localparam logic [SUB_W-1:0] SUB_RET  = 5'b10100;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SLOT = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // True for opcodes that must not sit in a delay slot.
    function automatic logic slot_forbidden(input logic [OPC_W-1:0] opc);
        return (opc == OPC_IMM)  || (opc == OPC_BR)  || (opc == OPC_BRC) ||
               (opc == OPC_BRI)  || (opc == OPC_BRCI) || (opc == OPC_RET);
    endfunction

endpackage

// File: rtl/rted_decode.sv
// Field splitter and classifier for the decode-stage word.
// Purely combinational; assumes the word layout in rtedu_pkg.
module rted_decode
    import rtedu_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_ret,
    output logic               is_forbidden,
    output logic [IDX_W-1:0]   base_idx,
    output logic [IMM_W-1:0]   imm
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int SUB_LSB = OPC_LSB - SUB_W;
    localparam int IDX_LSB = SUB_LSB - IDX_W;

    logic [OPC_W-1:0] opc;
    logic [SUB_W-1:0] sub;

    // Split the word into its fields.
    always_comb begin
        opc      = instr[INSTR_W-1:OPC_LSB];
        sub      = instr[OPC_LSB-1:SUB_LSB];
        base_idx = instr[SUB_LSB-1:IDX_LSB];
        imm      = instr[IMM_W-1:0];
    end

    // Classify the word as a return or as a forbidden slot occupant.
    always_comb begin
        is_ret       = (opc == OPC_RET) && (sub == SUB_RET);
        is_forbidden = slot_forbidden(opc);
    end

endmodule

// File: rtl/rted_target.sv
// Target adder and holding register.
// Adds the sign-extended immediate to the base value on load and keeps the
// sum until the next load. Assumes XLEN >= IMM_W.
module rted_target #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  target
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    // Widen the immediate by copying its sign bit.
    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_noext
            assign imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    // Capture the sum at decode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target <= '0;
        else if (load)
            target <= base + imm_ext;
    end

endmodule

// File: rtl/rted_seq.sv
// Sequencer: decode, delay-slot wait, redirect.
// Holds interrupts and breaks over the sequence, issues the status write,
// and raises the privilege exception. Assumes priv_block is already gated
// by the privilege-check parameter.
module rted_seq
    import rtedu_pkg::*;
#(
    parameter logic [4:0] PRIV_CAUSE = 5'b00111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_valid,
    input  logic       dec_ret,
    input  logic       dec_forbidden,
    input  logic       priv_block,
    input  logic       cur_ums,
    input  logic       cur_vms,
    input  logic       irq_req,
    input  logic       brk_req,
    output logic       load_target,
    output logic       busy,
    output logic       branch_valid,
    output logic       st_we,
    output logic       st_ee,
    output logic       st_eip,
    output logic       st_um,
    output logic       st_vm,
    output logic       priv_exc,
    output logic       esr_we,
    output logic [4:0] esr_cause,
    output logic       irq_take,
    output logic       brk_take,
    output logic       ds_illegal
);
    seq_state_e state;
    logic       hit;
    logic       hold;
    logic       priv_q;
    logic       ums_q;
    logic       vms_q;
    logic       bad_q;

    // Recognise a return accepted in the idle state.
    always_comb begin
        hit         = instr_valid && dec_ret && (state == SEQ_IDLE);
        load_target = hit && !priv_block;
        hold        = hit || (state != SEQ_IDLE);
    end

    // Advance the sequence and capture saved bits and slot class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            priv_q <= 1'b0;
            ums_q  <= 1'b0;
            vms_q  <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            priv_q <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (hit) begin
                        if (priv_block) begin
                            priv_q <= 1'b1;
                        end else begin
                            state <= SEQ_SLOT;
                            ums_q <= cur_ums;
                            vms_q <= cur_vms;
                        end
                    end
                end
                SEQ_SLOT: begin
                    if (instr_valid) begin
                        state <= SEQ_DONE;
                        bad_q <= dec_forbidden;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Drive redirect, status, exception and hold outputs from the state.
    always_comb begin
        busy         = (state != SEQ_IDLE);
        branch_valid = (state == SEQ_DONE);
        st_we        = branch_valid;
        st_ee        = branch_valid;
        st_eip       = 1'b0;
        st_um        = branch_valid && ums_q;
        st_vm        = branch_valid && vms_q;
        ds_illegal   = branch_valid && bad_q;
        priv_exc     = priv_q;
        esr_we       = priv_q;
        esr_cause    = priv_q ? PRIV_CAUSE : 5'b00000;
        irq_take     = irq_req && !hold;
        brk_take     = brk_req && !hold;
    end

endmodule

// File: rtl/rted_unit.sv
// Exception return control unit, top level.
// Ties the decoder, target adder and sequencer together; the privilege
// gate is chosen by PRIV_CHECK. Assumes a same-cycle register file read.
module rted_unit #(
    parameter int         XLEN       = 32,
    parameter int         IMM_W      = 16,
    parameter int         PRIV_CHECK = 1,
    parameter logic [4:0] PRIV_CAUSE = 5'b00111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] base_val,
    input  logic            cur_um,
    input  logic            cur_ums,
    input  logic            cur_vms,
    input  logic            irq_req,
    input  logic            brk_req,
    output logic [4:0]      base_idx,
    output logic            busy,
    output logic            branch_valid,
    output logic [XLEN-1:0] branch_target,
    output logic            st_we,
    output logic            st_ee,
    output logic            st_eip,
    output logic            st_um,
    output logic            st_vm,
    output logic            priv_exc,
    output logic            esr_we,
    output logic [4:0]      esr_cause,
    output logic            irq_take,
    output logic            brk_take,
    output logic            ds_illegal
);
    logic             dec_ret;
    logic             dec_forbidden;
    logic [IMM_W-1:0] dec_imm;
    logic             priv_block;
    logic             load_target;

    // Select whether user mode blocks the return.
    generate
        if (PRIV_CHECK != 0) begin : g_priv
            assign priv_block = cur_um;
        end else begin : g_nopriv
            assign priv_block = 1'b0;
        end
    endgenerate

    rted_decode #(.IMM_W(IMM_W)) u_dec (
        .instr        (instr),
        .is_ret       (dec_ret),
        .is_forbidden (dec_forbidden),
        .base_idx     (base_idx),
        .imm          (dec_imm)
    );

    rted_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_target),
        .base   (base_val),
        .imm    (dec_imm),
        .target (branch_target)
    );

    rted_seq #(.PRIV_CAUSE(PRIV_CAUSE)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .dec_ret       (dec_ret),
        .dec_forbidden (dec_forbidden),
        .priv_block    (priv_block),
        .cur_ums       (cur_ums),
        .cur_vms       (cur_vms),
        .irq_req       (irq_req),
        .brk_req       (brk_req),
        .load_target   (load_target),
        .busy          (busy),
        .branch_valid  (branch_valid),
        .st_we         (st_we),
        .st_ee         (st_ee),
        .st_eip        (st_eip),
        .st_um         (st_um),
        .st_vm         (st_vm),
        .priv_exc      (priv_exc),
        .esr_we        (esr_we),
        .esr_cause     (esr_cause),
        .irq_take      (irq_take),
        .brk_take      (brk_take),
        .ds_illegal    (ds_illegal)
    );

endmodule

// File: rtl/rtedu_checker.sv
// Temporal checks on the exception return unit's ports, bound to every
// instance of rted_unit.
module rtedu_checker #(
    parameter logic [4:0] PRIV_CAUSE = 5'b00111
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       branch_valid,
    input logic       st_we,
    input logic       st_ee,
    input logic       st_eip,
    input logic       priv_exc,
    input logic       esr_we,
    input logic [4:0] esr_cause,
    input logic       irq_take,
    input logic       brk_take,
    input logic       ds_illegal
);
    p_branch_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> $past(busy));

    p_redirect_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |=> !branch_valid);

    p_priv_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        priv_exc |=> !priv_exc);

    p_priv_no_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        priv_exc |-> (!branch_valid && !st_we && esr_we && esr_cause == PRIV_CAUSE));

    p_status_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (st_we && st_ee && !st_eip));

    p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || branch_valid) |-> (!irq_take && !brk_take));

    p_illegal_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ds_illegal |-> branch_valid);

endmodule

bind rted_unit rtedu_checker #(.PRIV_CAUSE(PRIV_CAUSE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .branch_valid (branch_valid),
    .st_we        (st_we),
    .st_ee        (st_ee),
    .st_eip       (st_eip),
    .priv_exc     (priv_exc),
    .esr_we       (esr_we),
    .esr_cause    (esr_cause),
    .irq_take     (irq_take),
    .brk_take     (brk_take),
    .ds_illegal   (ds_illegal)
);

// File: tb/rted_unit_tb_top.sv
module rted_unit_tb_top;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] imm;
        logic        um;
        logic        ums;
        logic        vms;
        logic [5:0]  slot_opc;
        logic        bad;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 16'h0010, 1'b0, 1'b1, 1'b0, 6'b000000, 1'b0},
        '{32'h0000_2000, 16'hFFFC, 1'b0, 1'b0, 1'b1, 6'b100110, 1'b1},
        '{32'hFFFF_FFF0, 16'h0020, 1'b0, 1'b1, 1'b1, 6'b101100, 1'b1},
        '{32'h8000_0000, 16'h8000, 1'b0, 1'b0, 1'b0, 6'b110000, 1'b0},
        '{32'h0000_4000, 16'h0004, 1'b1, 1'b1, 1'b0, 6'b000000, 1'b0},
        '{32'h1234_0000, 16'h7FFF, 1'b1, 1'b0, 1'b1, 6'b101111, 1'b1},
        '{32'h0000_0100, 16'hFF00, 1'b0, 1'b1, 1'b0, 6'b101101, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic        cur_um = 1'b0;
    logic        cur_ums = 1'b0;
    logic        cur_vms = 1'b0;
    logic        irq_req = 1'b0;
    logic        brk_req = 1'b0;

    logic [4:0]  base_idx, esr_cause, np_base_idx, np_esr_cause;
    logic        busy, branch_valid, st_we, st_ee, st_eip, st_um, st_vm;
    logic        priv_exc, esr_we, irq_take, brk_take, ds_illegal;
    logic [31:0] branch_target, np_target;
    logic        np_busy, np_bv, np_we, np_ee, np_eip, np_um, np_vm;
    logic        np_priv, np_esr_we, np_irq, np_brk, np_ill;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rted_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .base_val(base_val), .cur_um(cur_um), .cur_ums(cur_ums), .cur_vms(cur_vms),
        .irq_req(irq_req), .brk_req(brk_req), .base_idx(base_idx), .busy(busy),
        .branch_valid(branch_valid), .branch_target(branch_target), .st_we(st_we),
        .st_ee(st_ee), .st_eip(st_eip), .st_um(st_um), .st_vm(st_vm),
        .priv_exc(priv_exc), .esr_we(esr_we), .esr_cause(esr_cause),
        .irq_take(irq_take), .brk_take(brk_take), .ds_illegal(ds_illegal)
    );

    rted_unit #(.PRIV_CHECK(0)) dut_np (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .base_val(base_val), .cur_um(cur_um), .cur_ums(cur_ums), .cur_vms(cur_vms),
        .irq_req(irq_req), .brk_req(brk_req), .base_idx(np_base_idx), .busy(np_busy),
        .branch_valid(np_bv), .branch_target(np_target), .st_we(np_we),
        .st_ee(np_ee), .st_eip(np_eip), .st_um(np_um), .st_vm(np_vm),
        .priv_exc(np_priv), .esr_we(np_esr_we), .esr_cause(np_esr_cause),
        .irq_take(np_irq), .brk_take(np_brk), .ds_illegal(np_ill)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    function automatic logic [31:0] ret_word(input logic [4:0] ra, input logic [15:0] imm);
        return {6'b101101, 5'b10100, ra, imm};
    endfunction

    task automatic run_vec(input vec_t v);
        logic [31:0] exp_t;
        exp_t = v.base + {{16{v.imm[15]}}, v.imm};
        // decode cycle
        @(negedge clk);
        instr_valid = 1'b1; instr = ret_word(5'd17, v.imm); base_val = v.base;
        cur_um = v.um; cur_ums = v.ums; cur_vms = v.vms; irq_req = 1'b1; brk_req = 1'b1;
        #1;
        eq("R1 base_idx", {27'd0, base_idx}, 32'd17);
        eq("R8 irq held at decode", {31'd0, irq_take}, 32'd0);
        eq("R8 brk held at decode", {31'd0, brk_take}, 32'd0);
        // slot cycle
        @(negedge clk);
        if (v.um) begin
            eq("R4 priv_exc", {31'd0, priv_exc}, 32'd1);
            eq("R4 esr_we", {31'd0, esr_we}, 32'd1);
            eq("R4 esr_cause", {27'd0, esr_cause}, 32'd7);
            eq("R4 no busy", {31'd0, busy}, 32'd0);
        end else begin
            eq("R3 busy in slot wait", {31'd0, busy}, 32'd1);
            eq("R3 no early redirect", {31'd0, branch_valid}, 32'd0);
        end
        eq("R5 np busy", {31'd0, np_busy}, 32'd1);
        instr = {v.slot_opc, 26'd0}; cur_ums = ~v.ums; cur_vms = ~v.vms;
        #1;
        eq("R8 irq in slot", {31'd0, irq_take}, {31'd0, v.um});
        // redirect cycle
        @(negedge clk);
        instr_valid = 1'b0;
        if (v.um) begin
            eq("R4 no redirect", {31'd0, branch_valid}, 32'd0);
            eq("R4 no status write", {31'd0, st_we}, 32'd0);
            eq("R4 pulse ended", {31'd0, priv_exc}, 32'd0);
        end else begin
            eq("R3 redirect", {31'd0, branch_valid}, 32'd1);
            eq("R2 target", branch_target, exp_t);
            eq("R6 st_we", {31'd0, st_we}, 32'd1);
            eq("R6 st_ee", {31'd0, st_ee}, 32'd1);
            eq("R6 st_eip", {31'd0, st_eip}, 32'd0);
            eq("R7 st_um", {31'd0, st_um}, {31'd0, v.ums});
            eq("R7 st_vm", {31'd0, st_vm}, {31'd0, v.vms});
            eq("R9 ds_illegal", {31'd0, ds_illegal}, {31'd0, v.bad});
            eq("R8 irq held at redirect", {31'd0, irq_take}, 32'd0);
        end
        eq("R5 np redirect", {31'd0, np_bv}, 32'd1);
        eq("R5 np target", np_target, exp_t);
        eq("R7 np st_um", {31'd0, np_um}, {31'd0, v.ums});
        eq("R9 np ds_illegal", {31'd0, np_ill}, {31'd0, v.bad});
        // after
        @(negedge clk);
        eq("R3 redirect one cycle", {31'd0, branch_valid}, 32'd0);
        eq("R8 irq released", {31'd0, irq_take}, 32'd1);
        eq("R8 brk released", {31'd0, brk_take}, 32'd1);
        irq_req = 1'b0; brk_req = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 5000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        eq("R10 busy in reset", {31'd0, busy}, 32'd0);
        eq("R10 branch in reset", {31'd0, branch_valid}, 32'd0);
        eq("R10 priv in reset", {31'd0, priv_exc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        eq("R10 idle after reset", {31'd0, busy | st_we | esr_we | ds_illegal}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1 near-miss encoding is ignored
        @(negedge clk);
        instr_valid = 1'b1; instr = {6'b101101, 5'b10000, 5'd3, 16'h0001};
        irq_req = 1'b1; cur_um = 1'b0;
        #1;
        eq("R1 near miss no hold", {31'd0, irq_take}, 32'd1);
        eq("R1 base_idx near miss", {27'd0, base_idx}, 32'd3);
        @(negedge clk);
        instr_valid = 1'b0;
        eq("R1 near miss idle", {31'd0, busy}, 32'd0);

        // R3 stalled slot
        instr_valid = 1'b1; instr = ret_word(5'd1, 16'h0008); base_val = 32'h50;
        cur_ums = 1'b1; cur_vms = 1'b0;
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            eq("R3 stall no redirect", {31'd0, branch_valid}, 32'd0);
            eq("R3 stall busy", {31'd0, busy}, 32'd1);
        end
        instr_valid = 1'b1; instr = 32'd0;
        @(negedge clk);
        instr_valid = 1'b0;
        eq("R3 stall redirect", {31'd0, branch_valid}, 32'd1);
        eq("R2 stall target", branch_target, 32'h58);
        @(negedge clk);

        // R10 reset mid-sequence
        instr_valid = 1'b1; instr = ret_word(5'd2, 16'h0004);
        @(negedge clk);
        instr_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        eq("R10 abandoned", {31'd0, busy}, 32'd0);
        instr_valid = 1'b1; instr = 32'd0;
        @(negedge clk);
        instr_valid = 1'b0;
        eq("R10 no redirect after reset", {31'd0, branch_valid}, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule